// File: doc/BRIEF.md
# Wrapping DMA Write Address Engine

This block sits between a DMA word stream and a sample memory of 2^ADDR_W sixteen-bit words. Software programs a first address, a watch address, an interrupt enable and a source base, then writes the burst length, which launches the burst. The engine accepts one word per clock through a valid/ready handshake. It emits each word as a registered write to consecutive memory addresses, and the address rolls over from the top of memory to zero.

When the burst finishes, the engine reports where the burst stopped. It moves the first-address register to that point, rounded down to a 16-word boundary, so the next burst carries on from there. It records the word count and advances the source base by the byte count. The interrupt fires when the span just written covers the watch address. The span test takes a different form for a burst that rolled over than for one that did not. The interrupt stays raised until it is acknowledged.

Register map for `reg_addr`: 0 = first address (low ADDR_W bits of `reg_wdata` kept), 1 = watch address (low ADDR_W bits), 2 = interrupt enable (bit 0), 3 = source base (all SRC_W bits), 4 = burst length in words (low ADDR_W bits), and a write to 4 launches the burst.

Top module: `wdma_write_engine`

## Requirements
- R1: After a launch with first address S, the k-th accepted word (k from 0) appears on `mem_data` with `mem_addr` = (S+k) mod 2^ADDR_W and `mem_we` high in the cycle after its handshake, and words keep their arrival order.
- R2: A burst whose addresses pass 2^ADDR_W-1 continues at address 0 with the next word.
- R3: For a burst with S+L <= 2^ADDR_W, `end_addr` (ADDR_W+1 bits) becomes S+L, which may equal 2^ADDR_W.
- R4: For a burst with S+L > 2^ADDR_W, `end_addr` becomes (S+L+1) mod 2^ADDR_W.
- R5: For a burst that does not roll over, `irq` is set at completion exactly when enable is 1 and S <= watch < `end_addr`.
- R6: For a burst that rolls over, `irq` is set at completion exactly when enable is 1 and either watch >= S or watch < `end_addr`.
- R7: At completion, `start_addr` becomes the low ADDR_W bits of `end_addr` with bits [3:0] cleared.
- R8: At completion, `word_count` becomes L, `byte_count` is 2*L, and `src_addr` grows by 2*L.
- R9: `in_ready` is high only while `busy` is high, and a word is taken on every clock in which `in_valid` is high during the burst. `done` pulses high for one cycle, the cycle after the last write, with `busy` already low.
- R10: `irq` stays high until a cycle with `irq_ack` high clears it, and it rises only together with `done`.
- R11: A zero-length launch performs no memory write, sets no interrupt, and still pulses `done`.
- R12: Register writes, including a further length write, have no effect while `busy` is high.
- R13: After reset, `busy`, `done`, `irq`, `in_ready`, `mem_we`, `start_addr`, `end_addr` and `word_count` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | SRC_W | Register write data |
| in_valid | input | 1 | Stream word valid |
| in_data | input | DATA_W | Stream word |
| in_ready | output | 1 | Engine accepts a word |
| mem_addr | output | ADDR_W | Memory write address |
| mem_data | output | DATA_W | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| irq | output | 1 | Sticky watch-address interrupt |
| irq_ack | input | 1 | Clears the interrupt |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle completion pulse |
| start_addr | output | ADDR_W | Current first-address register |
| end_addr | output | ADDR_W+1 | Address reached by the last burst |
| src_addr | output | SRC_W | Source base register |
| word_count | output | ADDR_W | Word count of the last burst |
| byte_count | output | ADDR_W+1 | Byte count of the last burst |

## Verification
The hardest cases are the edges of the span test. These are a watch address one below the first address, at the first address, just below the end, at the end, and a burst that ends exactly at the top of memory without rolling over. Each is reached only by a specific pairing of first address and length. The bench shrinks memory to 64 words and sweeps first addresses and lengths on both sides of the rollover point. For each pair it places the watch address on every one of those edges and computes the expected end, realignment and interrupt arithmetically. Some bursts stall the stream every third cycle. Others write registers in the middle of the burst to show that those writes are ignored.

// File: rtl/wdma_pkg.sv
package wdma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } wdma_state_e;

  localparam logic [2:0] RA_FIRST = 3'd0;
  localparam logic [2:0] RA_WATCH = 3'd1;
  localparam logic [2:0] RA_IRQEN = 3'd2;
  localparam logic [2:0] RA_SRC   = 3'd3;
  localparam logic [2:0] RA_LEN   = 3'd4;
endpackage

// File: rtl/wdma_span.sv
// Combinational span arithmetic: rollover flag, end address, watch hit.
module wdma_span #(
  parameter int ADDR_W = 20
) (
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] len,
  input  logic [ADDR_W-1:0] watch,
  input  logic              irq_en,
  output logic              rolled,
  output logic [ADDR_W:0]   stop_addr,
  output logic              hit
);
  localparam logic [ADDR_W:0] MEM_TOP = {1'b1, {ADDR_W{1'b0}}};

  logic [ADDR_W:0] sum;
  logic [ADDR_W:0] sum_p1;
  logic [ADDR_W:0] watch_x;
  logic [ADDR_W:0] first_x;

  always_comb begin
    first_x   = {1'b0, first};
    watch_x   = {1'b0, watch};
    sum       = first_x + {1'b0, len};
    sum_p1    = sum + {{ADDR_W{1'b0}}, 1'b1};
    rolled    = (sum > MEM_TOP);
    stop_addr = rolled ? {1'b0, sum_p1[ADDR_W-1:0]} : sum;
    if (rolled)
      hit = irq_en && ((watch_x >= first_x) || (watch_x < stop_addr));
    else
      hit = irq_en && (watch_x >= first_x) && (watch_x < stop_addr);
  end
endmodule

// File: rtl/wdma_regs.sv
// Programmable registers, launch decode and completion bookkeeping.
module wdma_regs
  import wdma_pkg::*;
#(
  parameter int ADDR_W     = 20,
  parameter int SRC_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [SRC_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              finish,
  input  logic [ADDR_W:0]   stop_addr,
  input  logic              hit,
  input  logic              irq_ack,
  output logic              launch,
  output logic [ADDR_W-1:0] launch_len,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] watch_q,
  output logic              irq_en_q,
  output logic [ADDR_W-1:0] len_q,
  output logic [SRC_W-1:0]  src_q,
  output logic [ADDR_W:0]   end_q,
  output logic [ADDR_W-1:0] count_q,
  output logic              irq_q
);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'((1 << ALIGN_BITS) - 1);
  localparam int PAD_W = SRC_W - ADDR_W - 1;

  logic accept;
  logic [SRC_W-1:0] byte_step;

  assign accept     = reg_wr && !busy;
  assign launch     = accept && (reg_addr == RA_LEN);
  assign launch_len = reg_wdata[ADDR_W-1:0];
  assign byte_step  = {{PAD_W{1'b0}}, len_q, 1'b0};

  always_ff @(posedge clk) begin
    if (rst) begin
      first_q  <= '0;
      watch_q  <= '0;
      irq_en_q <= 1'b0;
      len_q    <= '0;
      src_q    <= '0;
      end_q    <= '0;
      count_q  <= '0;
    end else if (finish) begin
      first_q <= stop_addr[ADDR_W-1:0] & ~ALIGN_MASK;
      end_q   <= stop_addr;
      count_q <= len_q;
      src_q   <= src_q + byte_step;
    end else if (accept) begin
      case (reg_addr)
        RA_FIRST: first_q  <= reg_wdata[ADDR_W-1:0];
        RA_WATCH: watch_q  <= reg_wdata[ADDR_W-1:0];
        RA_IRQEN: irq_en_q <= reg_wdata[0];
        RA_SRC:   src_q    <= reg_wdata;
        RA_LEN:   len_q    <= reg_wdata[ADDR_W-1:0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_q <= 1'b0;
    else if (finish && hit)
      irq_q <= 1'b1;
    else if (irq_ack)
      irq_q <= 1'b0;
  end
endmodule

// File: rtl/wdma_seq.sv
// Burst sequencer: stream handshake, rolling address, registered writes.
module wdma_seq
  import wdma_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [ADDR_W-1:0] launch_len,
  input  logic [ADDR_W-1:0] first,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_we,
  output logic              busy,
  output logic              finish,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

  wdma_state_e       state;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] remain;

  assign in_ready = (state == ST_RUN);
  assign busy     = (state != ST_IDLE);
  assign finish   = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      mem_we   <= 1'b0;
      mem_addr <= '0;
      mem_data <= '0;
      done     <= 1'b0;
    end else begin
      mem_we <= 1'b0;
      done   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (launch) begin
            cur_addr <= first;
            remain   <= launch_len;
            state    <= (launch_len == '0) ? ST_FIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (in_valid) begin
            mem_we   <= 1'b1;
            mem_addr <= cur_addr;
            mem_data <= in_data;
            cur_addr <= cur_addr + ONE;
            remain   <= remain - ONE;
            if (remain == ONE)
              state <= ST_FIN;
          end
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wdma_write_engine.sv
module wdma_write_engine #(
  parameter int ADDR_W     = 20,
  parameter int DATA_W     = 16,
  parameter int SRC_W      = 32,
  parameter int ALIGN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [SRC_W-1:0]  reg_wdata,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic              mem_we,
  output logic              irq,
  input  logic              irq_ack,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] start_addr,
  output logic [ADDR_W:0]   end_addr,
  output logic [SRC_W-1:0]  src_addr,
  output logic [ADDR_W-1:0] word_count,
  output logic [ADDR_W:0]   byte_count
);
  logic              launch;
  logic [ADDR_W-1:0] launch_len;
  logic [ADDR_W-1:0] watch_q;
  logic              irq_en_q;
  logic [ADDR_W-1:0] len_q;
  logic              finish;
  logic              rolled;
  logic [ADDR_W:0]   stop_addr;
  logic              hit;

  wdma_regs #(
    .ADDR_W(ADDR_W), .SRC_W(SRC_W), .ALIGN_BITS(ALIGN_BITS)
  ) u_regs (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .busy(busy), .finish(finish), .stop_addr(stop_addr), .hit(hit),
    .irq_ack(irq_ack),
    .launch(launch), .launch_len(launch_len),
    .first_q(start_addr), .watch_q(watch_q), .irq_en_q(irq_en_q),
    .len_q(len_q), .src_q(src_addr), .end_q(end_addr),
    .count_q(word_count), .irq_q(irq)
  );

  wdma_span #(.ADDR_W(ADDR_W)) u_span (
    .first(start_addr), .len(len_q), .watch(watch_q), .irq_en(irq_en_q),
    .rolled(rolled), .stop_addr(stop_addr), .hit(hit)
  );

  wdma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst),
    .launch(launch), .launch_len(launch_len), .first(start_addr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_we(mem_we),
    .busy(busy), .finish(finish), .done(done)
  );

  assign byte_count = {word_count, 1'b0};

  logic unused_rolled;
  assign unused_rolled = rolled;
endmodule

// File: rtl/wdma_write_engine_chk.sv
module wdma_write_engine_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              busy,
  input logic              done,
  input logic              irq,
  input logic              irq_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] start_addr
);
  a_r9_ready_only_busy: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> busy);

  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r9_done_when_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r10_irq_sticky: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_ack) |=> irq);

  a_r10_irq_with_done: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> done);

  a_r1_write_in_burst: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  a_r12_first_frozen: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(start_addr));
endmodule

bind wdma_write_engine wdma_write_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .busy(busy), .done(done),
  .irq(irq), .irq_ack(irq_ack), .mem_we(mem_we), .start_addr(start_addr)
);

// File: tb/sim_wdma_write_engine.sv
module sim_wdma_write_engine;
  localparam int CLK_NS = 10;
  localparam int AW  = 6;
  localparam int MEM = 64;
  localparam int SW  = 32;
  localparam int DW  = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [SW-1:0] reg_wdata = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic          mem_we;
  logic          irq;
  logic          irq_ack = 1'b0;
  logic          busy;
  logic          done;
  logic [AW-1:0] start_addr;
  logic [AW:0]   end_addr;
  logic [SW-1:0] src_addr;
  logic [AW-1:0] word_count;
  logic [AW:0]   byte_count;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit mon_on = 0;
  int mon_start, mon_cnt, mon_seed, mon_first, mon_last;

  wdma_write_engine #(.ADDR_W(AW), .DATA_W(DW), .SRC_W(SW), .ALIGN_BITS(4)) u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_we(mem_we), .irq(irq), .irq_ack(irq_ack), .busy(busy), .done(done),
    .start_addr(start_addr), .end_addr(end_addr), .src_addr(src_addr),
    .word_count(word_count), .byte_count(byte_count)
  );

  always #(CLK_NS/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [DW-1:0] pat(int seed, int i);
    return DW'((seed * 97 + i * 13 + 5) ^ (i << 8));
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && mem_we) begin
      chk(int'(mem_addr) == (mon_start + mon_cnt) % MEM,
          ((mon_start + mon_cnt) >= MEM) ? "R2" : "R1", "write address",
          mem_addr, (mon_start + mon_cnt) % MEM);
      chk(mem_data == pat(mon_seed, mon_cnt), "R1", "write data",
          mem_data, pat(mon_seed, mon_cnt));
      if (mon_cnt == 0) mon_first = cyc;
      mon_last = cyc;
      mon_cnt++;
    end
  end

  task automatic reg_write(logic [2:0] a, int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = SW'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic run_burst(int s, int l, int w, bit en, int src, int seed,
                           bit gap, bit poke);
    int sum, e, startn, i, k, t;
    bit rolled, hit;
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(irq == 1'b0, "R10", "irq after ack", irq, 0);
    reg_write(3'd0, s);
    reg_write(3'd1, w);
    reg_write(3'd2, int'(en));
    reg_write(3'd3, src);
    sum    = s + l;
    rolled = sum > MEM;
    e      = rolled ? (sum + 1) % MEM : sum;
    hit    = en && (rolled ? (w >= s || w < e) : (w >= s && w < e));
    startn = (e % MEM) & ~15;
    mon_start = s; mon_cnt = 0; mon_seed = seed; mon_on = 1;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = SW'(l);
    @(negedge clk);
    reg_wr = 1'b0;
    if (poke && l > 0) begin
      chk(busy == 1'b1, "R9", "busy after launch", busy, 1);
      reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = SW'(!en);
      @(negedge clk); reg_addr = 3'd0; reg_wdata = SW'(s ^ 7);
      @(negedge clk); reg_addr = 3'd1; reg_wdata = SW'(w ^ 33);
      @(negedge clk); reg_addr = 3'd3; reg_wdata = 32'h0;
      @(negedge clk); reg_addr = 3'd4; reg_wdata = SW'(5);
      @(negedge clk); reg_wr = 1'b0;
    end
    i = 0; k = 0;
    while (i < l) begin
      @(negedge clk);
      k++;
      if (gap && (k % 3 == 1)) in_valid = 1'b0;
      else begin in_valid = 1'b1; in_data = pat(seed, i); end
      if (in_valid && in_ready) i++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R9", "done pulse", done, 1);
    chk(busy == 1'b0, "R9", "busy at done", busy, 0);
    chk(mon_cnt == l, (l == 0) ? "R11" : "R1", "write count", mon_cnt, l);
    if (!gap && l > 1)
      chk(mon_last - mon_first == l - 1, "R9", "one word per clock",
          mon_last - mon_first, l - 1);
    chk(int'(end_addr) == e, rolled ? "R4" : "R3", "end address", end_addr, e);
    chk(int'(start_addr) == startn, poke ? "R12" : "R7", "realigned first",
        start_addr, startn);
    chk(int'(word_count) == l, "R8", "word count", word_count, l);
    chk(int'(byte_count) == 2 * l, "R8", "byte count", byte_count, 2 * l);
    chk(src_addr == SW'(src + 2 * l), poke ? "R12" : "R8", "source advance",
        src_addr, SW'(src + 2 * l));
    chk(irq == hit, poke ? "R12" : (l == 0 ? "R11" : (rolled ? "R6" : "R5")),
        "irq", irq, hit);
    @(negedge clk);
    chk(done == 1'b0, "R9", "done single cycle", done, 0);
    chk(busy == 1'b0, poke ? "R12" : "R9", "no relaunch", busy, 0);
    mon_on = 0;
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL R9 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int starts[7] = '{0, 1, 9, 31, 40, 58, 63};
    int lens[5]   = '{0, 1, 6, 33, 63};
    int seed = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0, "R13", "busy", busy, 0);
    chk(done == 0, "R13", "done", done, 0);
    chk(irq == 0, "R13", "irq", irq, 0);
    chk(in_ready == 0, "R13", "in_ready", in_ready, 0);
    chk(mem_we == 0, "R13", "mem_we", mem_we, 0);
    chk(start_addr == 0, "R13", "start_addr", start_addr, 0);
    chk(end_addr == 0, "R13", "end_addr", end_addr, 0);
    chk(word_count == 0, "R13", "word_count", word_count, 0);

    for (int si = 0; si < 7; si++) begin
      for (int li = 0; li < 5; li++) begin
        int s, l, e, sum;
        int wl[7];
        s = starts[si]; l = lens[li]; sum = s + l;
        e = (sum > MEM) ? (sum + 1) % MEM : sum;
        wl[0] = s; wl[1] = (s + MEM - 1) % MEM; wl[2] = (e + MEM - 1) % MEM;
        wl[3] = e % MEM; wl[4] = 0; wl[5] = MEM - 1; wl[6] = (s + l / 2) % MEM;
        for (int wi = 0; wi < 7; wi++) begin
          run_burst(s, l, wl[wi], wi != 4, 1000 * si + li, seed,
                    ((si + li + wi) % 2) == 1, 1'b0);
          seed++;
        end
      end
    end

    // R12: mid-burst writes to every register are ignored
    run_burst(50, 20, 55, 1'b1, 4000, 77, 1'b0, 1'b1);
    run_burst(3, 10, 5, 1'b1, 5000, 78, 1'b1, 1'b1);
    run_burst(3, 10, 5, 1'b0, 6000, 79, 1'b0, 1'b1);

    // R10: interrupt holds without acknowledge
    run_burst(10, 8, 12, 1'b1, 0, 80, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R10", "irq held", irq, 1);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    chk(irq == 1'b0, "R10", "irq cleared", irq, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule